// File: doc/BRIEF.md
# I2C Line Filter and Bus Condition Detector

This block sits between the raw, asynchronous clock and data pins of a two-wire serial bus and a slave protocol engine that runs on a fast system clock. Each line passes through a two-flop synchronizer and then a run-length glitch filter. A filtered line changes level only after its synchronized input has held the new value for `FILT_CYC` system clocks in a row.

From the filtered levels the block produces single-cycle pulses for clock rising and falling edges, START and STOP. It also produces a bus-idle level. A START is a falling data line while the clock is high. A STOP is a rising data line while the clock is high. Data changes while the clock is low are ordinary bits.

On the transmit side, the engine's request to pull the data line low is not applied to the open-drain output enable at once. After each filtered clock falling edge the output enable is frozen for a hold window of `HOLD_CYC` clocks. This means a data change never overlaps the slow falling edge of the clock, which would otherwise create a false START or STOP.

Top module: `i2c_line_frontend`

## Requirements
- R1: The first clock edge that samples a new pin level counts as edge 1. The filtered level (`scl_o`, `sda_o`) changes at clock edge `FILT_CYC`+2, provided the pin holds the new level for at least `FILT_CYC` cycles. The matching pulse is visible in the cycle after that edge.
- R2: A pin pulse of `FILT_CYC`-1 cycles or fewer is ignored. The filtered level does not change, and no edge, START or STOP pulse is produced.
- R3: `scl_rise_o` and `scl_fall_o` each pulse for exactly one cycle per filtered clock transition. They are never high together.
- R4: `start_o` pulses for one cycle when filtered SDA falls while filtered SCL is high (1).
- R5: `stop_o` pulses for one cycle when filtered SDA rises while filtered SCL is high (1).
- R6: An SDA change while filtered SCL is low (0) produces neither START nor STOP.
- R7: `idle_o` is high only when no transfer is open and both filtered lines are high. A START opens a transfer and a STOP closes it. While a transfer is open, `idle_o` stays low even when both lines are high.
- R8: After a cycle in which `scl_fall_o` is high, `sda_oe_o` holds its value for the next `HOLD_CYC`+1 clock edges. At the edge after that it takes the value that `sda_drive_i` had in the preceding cycle.
- R9: Outside a hold window, `sda_oe_o` equals `sda_drive_i` delayed by one clock (1 = pull SDA low).
- R10: After reset, `scl_o`=1, `sda_o`=1, `idle_o`=1, all pulses are 0 and `sda_oe_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw clock pin level |
| sda_i | input | 1 | Raw data pin level |
| sda_drive_i | input | 1 | Engine request to pull SDA low |
| scl_o | output | 1 | Filtered clock level |
| sda_o | output | 1 | Filtered data level |
| scl_rise_o | output | 1 | Filtered clock rising edge pulse |
| scl_fall_o | output | 1 | Filtered clock falling edge pulse |
| start_o | output | 1 | START condition pulse |
| stop_o | output | 1 | STOP condition pulse |
| idle_o | output | 1 | Bus free |
| sda_oe_o | output | 1 | Open-drain SDA pull-down enable |

## Verification
A filter counter that runs short or long shows up as a pulse arriving a cycle early or late. It can also show up as a short spike leaking through as a false edge, which appears within `FILT_CYC`+2 cycles of the spike. A stuck transfer flag shows as `idle_o` staying low after a STOP, or staying high during a transfer; this is visible one cycle after the condition pulse. An off-by-one in the hold timer moves the `sda_oe_o` change by one cycle relative to the `HOLD_CYC`+2 point after the falling-edge pulse. The benches sample exactly at that point.

// File: rtl/i2c_fe_pkg.sv
package i2c_fe_pkg;
  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } line_ev_t;
endpackage

// File: rtl/i2c_fe_filter.sv
module i2c_fe_filter
  import i2c_fe_pkg::*;
#(
  parameter int unsigned FILT_CYC = 13
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pin_i,
  output logic     sync_o,
  output line_ev_t ev_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;
  logic          lvl_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      run_q  <= '0;
      lvl_q  <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      prev_q <= lvl_q;
      if (sync_q[1] != lvl_q) begin
        if (run_q == LAST) begin
          lvl_q <= sync_q[1];
          run_q <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign sync_o    = sync_q[1];
  assign ev_o.lvl  = lvl_q;
  assign ev_o.rise = lvl_q & ~prev_q;
  assign ev_o.fall = ~lvl_q & prev_q;
endmodule

// File: rtl/i2c_fe_cond.sv
module i2c_fe_cond
  import i2c_fe_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  line_ev_t scl_ev_i,
  input  line_ev_t sda_ev_i,
  output logic     start_o,
  output logic     stop_o,
  output logic     idle_o
);
  logic busy_q;

  // SCL level sampled in the same cycle the filtered SDA edge is reported
  assign start_o = sda_ev_i.fall & scl_ev_i.lvl;
  assign stop_o  = sda_ev_i.rise & scl_ev_i.lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_q <= 1'b0;
    else if (start_o) busy_q <= 1'b1;
    else if (stop_o)  busy_q <= 1'b0;
  end

  assign idle_o = ~busy_q & scl_ev_i.lvl & sda_ev_i.lvl;
endmodule

// File: rtl/i2c_fe_sda_hold.sv
module i2c_fe_sda_hold #(
  parameter int unsigned HOLD_CYC = 75
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_fall_i,
  input  logic drive_i,
  output logic oe_o
);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] LOAD = HW'(HOLD_CYC);

  logic [HW-1:0] hold_q;
  logic          oe_q;
  logic          open_w;

  assign open_w = (hold_q == '0) & ~scl_fall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      if (scl_fall_i)        hold_q <= LOAD;
      else if (hold_q != '0) hold_q <= hold_q - 1'b1;
      if (open_w) oe_q <= drive_i;
    end
  end

  assign oe_o = oe_q;
endmodule

// File: rtl/i2c_line_frontend.sv
module i2c_line_frontend
  import i2c_fe_pkg::*;
#(
  parameter int unsigned FILT_CYC = 13,
  parameter int unsigned HOLD_CYC = 75
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic sda_drive_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic idle_o,
  output logic sda_oe_o
);
  line_ev_t ev_w [2];
  logic     sync_w [2];
  logic     pin_w  [2];

  assign pin_w[0] = scl_i;
  assign pin_w[1] = sda_i;

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_fe_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pin_w[g]),
      .sync_o (sync_w[g]),
      .ev_o   (ev_w[g])
    );
  end

  logic scl_sync, sda_sync;
  assign scl_sync = sync_w[0];
  assign sda_sync = sync_w[1];

  i2c_fe_cond u_cond (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_ev_i (ev_w[0]),
    .sda_ev_i (ev_w[1]),
    .start_o  (start_o),
    .stop_o   (stop_o),
    .idle_o   (idle_o)
  );

  i2c_fe_sda_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_fall_i (ev_w[0].fall),
    .drive_i    (sda_drive_i),
    .oe_o       (sda_oe_o)
  );

  assign scl_o      = ev_w[0].lvl;
  assign sda_o      = ev_w[1].lvl;
  assign scl_rise_o = ev_w[0].rise;
  assign scl_fall_o = ev_w[0].fall;
endmodule

// File: rtl/i2c_line_frontend_chk.sv
module i2c_line_frontend_chk #(
  parameter int unsigned HOLD_CYC = 75
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_sync_i,
  input logic sda_sync_i,
  input logic sda_drive_i,
  input logic scl_o,
  input logic sda_o,
  input logic scl_rise_o,
  input logic scl_fall_o,
  input logic start_o,
  input logic stop_o,
  input logic idle_o,
  input logic sda_oe_o
);
  int unsigned win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         win_q <= 0;
    else if (scl_fall_o) win_q <= HOLD_CYC;
    else if (win_q != 0) win_q <= win_q - 1;
  end

  // R1: filtered level only moves toward the synchronized value
  a_r1_scl_follows_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scl_o) |-> $past(scl_sync_i) == scl_o);
  a_r1_sda_follows_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_o) |-> $past(sda_sync_i) == sda_o);
  // R3
  a_r3_edges_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({scl_rise_o, scl_fall_o}));
  a_r3_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_fall_o |=> !scl_fall_o);
  // R4 / R7
  a_r4_start_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !idle_o);
  // R5
  a_r5_stop_not_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));
  // R7
  a_r7_idle_lines_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (scl_o && sda_o));
  // R8
  a_r8_hold_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_fall_o || win_q > 1) |=> $stable(sda_oe_o));
  // R9
  a_r9_oe_from_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> $past(sda_drive_i) == sda_oe_o);
endmodule

bind i2c_line_frontend i2c_line_frontend_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_sync_i  (scl_sync),
  .sda_sync_i  (sda_sync),
  .sda_drive_i (sda_drive_i),
  .scl_o       (scl_o),
  .sda_o       (sda_o),
  .scl_rise_o  (scl_rise_o),
  .scl_fall_o  (scl_fall_o),
  .start_o     (start_o),
  .stop_o      (stop_o),
  .idle_o      (idle_o),
  .sda_oe_o    (sda_oe_o)
);

// File: tb/i2c_line_frontend_tb.sv
module i2c_line_frontend_tb_top;
  localparam int F = 13;
  localparam int H = 75;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_i = 1'b1, sda_i = 1'b1, drv = 1'b0;
  logic scl_o, sda_o, scl_rise, scl_fall, start, stop, idle, oe;

  always #2 clk = ~clk;

  i2c_line_frontend #(.FILT_CYC(F), .HOLD_CYC(H)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_drive_i(drv), .scl_o(scl_o), .sda_o(sda_o),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .start_o(start),
    .stop_o(stop), .idle_o(idle), .sda_oe_o(oe)
  );

  int cyc = 0;
  int n_rise = 0, n_fall = 0, n_start = 0, n_stop = 0, n_both = 0;
  int n_long_rise = 0, n_long_fall = 0;
  int last_start = 0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (scl_rise) n_rise++;
    if (scl_fall) n_fall++;
    if (scl_rise && scl_fall) n_both++;
    if (start) begin n_start++; last_start = cyc; end
    if (stop) n_stop++;
  end

  // two-cycle-wide pulses would violate R3
  logic rise_d = 1'b0, fall_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_rise && rise_d) n_long_rise++;
    if (rst_n && scl_fall && fall_d) n_long_fall++;
    rise_d <= scl_rise;
    fall_d <= scl_fall;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (F + 6) @(negedge clk);
  endtask

  task automatic set_lines(input logic c, input logic d);
    @(negedge clk);
    scl_i = c;
    sda_i = d;
    settle();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 scl_o", scl_o, 1);
    chk("R10 sda_o", sda_o, 1);
    chk("R10 idle_o", idle, 1);
    chk("R10 pulses", {scl_rise, scl_fall, start, stop}, 0);
    chk("R10 sda_oe_o", oe, 0);
  endtask

  task automatic t_latency();
    int c0;
    int s0 = n_start;
    @(negedge clk);
    sda_i = 1'b0;
    c0 = cyc;
    settle();
    chk("R4 start count", n_start - s0, 1);
    chk("R1 start latency", last_start - c0, F + 2);
    chk("R7 idle low after start", idle, 0);
  endtask

  task automatic t_transfer();
    int s0 = n_start, p0 = n_stop, r0 = n_rise, f0 = n_fall;
    set_lines(1'b0, 1'b0);
    chk("R3 one fall", n_fall - f0, 1);
    set_lines(1'b0, 1'b1);
    set_lines(1'b1, 1'b1);
    chk("R3 one rise", n_rise - r0, 1);
    chk("R7 idle low mid transfer", idle, 0);
    set_lines(1'b0, 1'b1);
    set_lines(1'b0, 1'b0);
    set_lines(1'b0, 1'b1);
    set_lines(1'b0, 1'b0);
    chk("R6 no start on data", n_start - s0, 0);
    chk("R6 no stop on data", n_stop - p0, 0);
    set_lines(1'b1, 1'b0);
    set_lines(1'b1, 1'b1);
    chk("R5 stop count", n_stop - p0, 1);
    chk("R7 idle after stop", idle, 1);
    chk("R3 fall count", n_fall - f0, 2);
    chk("R3 rise count", n_rise - r0, 2);
  endtask

  task automatic t_glitch();
    int s0 = n_start, p0 = n_stop, f0 = n_fall, r0 = n_rise;
    @(negedge clk);
    sda_i = 1'b0;
    repeat (F - 1) @(negedge clk);
    sda_i = 1'b1;
    settle();
    chk("R2 sda glitch no start", n_start - s0, 0);
    chk("R2 sda level kept", sda_o, 1);
    @(negedge clk);
    scl_i = 1'b0;
    repeat (F - 1) @(negedge clk);
    scl_i = 1'b1;
    settle();
    chk("R2 scl glitch no edge", (n_fall - f0) + (n_rise - r0), 0);
    chk("R2 scl level kept", scl_o, 1);
    @(negedge clk);
    sda_i = 1'b0;
    repeat (F) @(negedge clk);
    sda_i = 1'b1;
    settle();
    chk("R1 F-cycle pulse start", n_start - s0, 1);
    chk("R1 F-cycle pulse stop", n_stop - p0, 1);
  endtask

  task automatic t_hold();
    int guard = 0;
    set_lines(1'b1, 1'b0);
    @(negedge clk);
    drv = 1'b0;
    scl_i = 1'b0;
    while (!scl_fall && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    chk("R3 fall seen", scl_fall, 1);
    drv = 1'b1;
    repeat (H + 1) @(negedge clk);
    chk("R8 oe held", oe, 0);
    @(negedge clk);
    chk("R8 oe released", oe, 1);
    drv = 1'b0;
    @(negedge clk);
    chk("R9 oe follows", oe, 0);
    drv = 1'b1;
    @(negedge clk);
    chk("R9 oe follows set", oe, 1);
    drv = 1'b0;
    set_lines(1'b1, 1'b0);
    set_lines(1'b1, 1'b1);
    chk("R7 idle end", idle, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    settle();
    t_latency();
    t_transfer();
    t_glitch();
    t_hold();
    chk("R3 no overlap", n_both, 0);
    chk("R3 rise single cycle", n_long_rise, 0);
    chk("R3 fall single cycle", n_long_fall, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule